// File: doc/BRIEF.md
# Fetch-Execute Control Sequencer

This block is the top-level control state machine of a small 8-bit controller core. It owns the program counter, presents it on the program-memory address bus, raises the program-memory read strobe for a single cycle, captures the returned opcode and hands it to the datapath with a one-cycle execute strobe. It then waits until the datapath reports that the instruction is finished, and only then advances the program counter.

The sequencer runs through a fixed loop of four phases. After reset it passes through a reserved interrupt phase, fetches, executes, and returns to the interrupt phase after every instruction. The interrupt phase does nothing yet; it only costs one cycle. If the datapath finishes in its first execute cycle, an instruction takes three clock cycles. Widths of the address and opcode buses are parameters.

Top module: `fetch_exec_seq`

## Requirements
- R1: A synchronous active-high `rst` forces the reset phase from any phase, clears the program counter to 0 and drives `pm_rd` and `ex_strobe` low on the following cycle. Reset takes priority over a simultaneous `ex_done`.
- R2: After `rst` is released, the phases run reset, interrupt, fetch. As a result, `pm_rd` first goes high in the cycle after the second rising clock edge with `rst` low.
- R3: `pm_rd` is high only in the fetch phase, for exactly one cycle per instruction. `pm_addr` always equals the program counter.
- R4: The opcode is sampled from `pm_data` on the clock edge that leaves fetch. `ex_opcode` then holds that value until the next fetch, whatever `pm_data` does in the meantime.
- R5: `ex_strobe` is a single-cycle pulse in the first execute cycle, that is, in the cycle right after the fetch cycle.
- R6: The sequencer stays in execute while `ex_done` is low. The program counter increases by one on the edge where `ex_done` is sampled high in execute. `ex_done` has no effect in any other phase.
- R7: After execute, the sequencer spends exactly one cycle in the interrupt phase, with `pm_rd` low, and then fetches again.
- R8: The program counter wraps from all ones to zero.
- R9: If `ex_done` is high in the same cycle as `ex_strobe`, the instruction completes in that cycle. Back-to-back instructions then take three cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pm_data | input | OP_W (8) | Opcode returned by program memory |
| ex_done | input | 1 | Datapath reports the current instruction is finished |
| pm_addr | output | ADDR_W (16) | Program-memory address, equal to the program counter |
| pm_rd | output | 1 | Program-memory read strobe, high in the fetch phase |
| ex_strobe | output | 1 | One-cycle start-of-execute pulse |
| ex_opcode | output | OP_W (8) | Latched opcode for the datapath |

## Verification
Two functions can fall in the same cycle: the completion of an instruction (`ex_done` high in execute, which increments the program counter) and a synchronous reset. The bench provokes this by raising `rst` and `ex_done` together while `ex_strobe` is high. It then requires the address to read 0 rather than the incremented value, and requires a normal restart through the interrupt phase. A second overlap, `ex_done` arriving together with `ex_strobe`, is judged by requiring the address to increase by one and the next read strobe to appear exactly three cycles later.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [1:0] {
      PH_RESET = 2'd0,
      PH_IRQ   = 2'd1,
      PH_FETCH = 2'd2,
      PH_EXEC  = 2'd3
   } phase_t;

endpackage

// File: rtl/fes_pc.sv
module fes_pc #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] PC_ZERO = '0;
   localparam logic [ADDR_W-1:0] PC_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("fes_pc: ADDR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         pc <= PC_ZERO;
      else if (advance)
         pc <= pc + PC_STEP;   // natural wrap from all ones to zero
   end

   // R8: stepping from all ones must land on zero
   assert_pc_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (advance && (pc == ~PC_ZERO)) |=> (pc == PC_ZERO));

endmodule

// File: rtl/fes_oplatch.sv
module fes_oplatch #(
   parameter int OP_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            capture,
   input  logic [OP_W-1:0] pm_data,
   output logic [OP_W-1:0] opcode
);

   generate
      if (OP_W < 1) begin : g_bad_width
         $error("fes_oplatch: OP_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         opcode <= '0;
      else if (capture)
         opcode <= pm_data;
   end

   // R4: the opcode holds between fetches
   assert_opcode_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !capture |=> $stable(opcode));

endmodule

// File: rtl/fes_fsm.sv
module fes_fsm
   import fes_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ex_done,
   output logic in_fetch,
   output logic exec_pulse,
   output logic advance
);

   phase_t ph;
   phase_t ph_nx;

   always_comb begin
      ph_nx = ph;
      unique case (ph)
         PH_RESET: ph_nx = PH_IRQ;
         PH_IRQ:   ph_nx = PH_FETCH;   // reserved, pass-through for now
         PH_FETCH: ph_nx = PH_EXEC;
         PH_EXEC:  if (ex_done) ph_nx = PH_IRQ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph         <= PH_RESET;
         exec_pulse <= 1'b0;
      end else begin
         ph         <= ph_nx;
         exec_pulse <= (ph == PH_FETCH);
      end
   end

   assign in_fetch = (ph == PH_FETCH);
   assign advance  = (ph == PH_EXEC) && ex_done;

   // R3: read strobe lasts one cycle
   assert_fetch_single_R3: assert property (@(posedge clk) disable iff (rst)
      in_fetch |=> !in_fetch);

   // R5: strobe follows fetch and lasts one cycle
   assert_strobe_after_fetch_R5: assert property (@(posedge clk) disable iff (rst)
      in_fetch |=> exec_pulse);
   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
      exec_pulse |=> !exec_pulse);

   // R7: one idle interrupt cycle, then fetch
   assert_irq_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
      advance |=> !in_fetch ##1 in_fetch);

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq #(
   parameter int ADDR_W = 16,
   parameter int OP_W   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   pm_data,
   input  logic              ex_done,
   output logic [ADDR_W-1:0] pm_addr,
   output logic              pm_rd,
   output logic              ex_strobe,
   output logic [OP_W-1:0]   ex_opcode
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic in_fetch;
   logic exec_pulse;
   logic advance;

   fes_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .ex_done    (ex_done),
      .in_fetch   (in_fetch),
      .exec_pulse (exec_pulse),
      .advance    (advance)
   );

   fes_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk     (clk),
      .rst     (rst),
      .advance (advance),
      .pc      (pm_addr)
   );

   fes_oplatch #(.OP_W(OP_W)) u_op (
      .clk     (clk),
      .rst     (rst),
      .capture (in_fetch),
      .pm_data (pm_data),
      .opcode  (ex_opcode)
   );

   assign pm_rd     = in_fetch;
   assign ex_strobe = exec_pulse;

   // R1: reset clears the visible state on the next cycle
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (pm_addr == '0) && !pm_rd && !ex_strobe);

   // R3: address stable across the fetch cycle
   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
      pm_rd |=> $stable(pm_addr));

   // R9: done with the strobe completes at once
   assert_zero_wait_R9: assert property (@(posedge clk) disable iff (rst)
      (ex_strobe && ex_done) |=> (pm_addr == $past(pm_addr) + ADDR_ONE));

endmodule

// File: tb/fetch_exec_seq_bench.sv
module fetch_exec_seq_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ex_done = 1'b0;
   logic [7:0]  key = 8'h00;
   logic [15:0] pm_addr;
   logic        pm_rd;
   logic        ex_strobe;
   logic [7:0]  ex_opcode;
   logic [7:0]  pm_data;
   logic [3:0]  s_addr;
   logic        s_rd;
   logic        s_strobe;
   logic [7:0]  s_opcode;
   logic [7:0]  s_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign pm_data = pm_addr[7:0] ^ 8'h5A ^ key;
   assign s_data  = {4'h0, s_addr} ^ 8'hA5;

   fetch_exec_seq u_fetch_exec_seq (
      .clk(clk), .rst(rst), .pm_data(pm_data), .ex_done(ex_done),
      .pm_addr(pm_addr), .pm_rd(pm_rd), .ex_strobe(ex_strobe), .ex_opcode(ex_opcode)
   );

   fetch_exec_seq #(.ADDR_W(4), .OP_W(8)) u_small (
      .clk(clk), .rst(rst), .pm_data(s_data), .ex_done(ex_done),
      .pm_addr(s_addr), .pm_rd(s_rd), .ex_strobe(s_strobe), .ex_opcode(s_opcode)
   );

   function automatic logic [7:0] exp_op(input logic [15:0] a, input logic [7:0] k);
      return a[7:0] ^ 8'h5A ^ k;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      repeat (3) tick();
      chk("R1", "addr in reset", 32'(pm_addr), 32'h0);
      chk("R1", "rd in reset", 32'(pm_rd), 32'h0);
      chk("R1", "strobe in reset", 32'(ex_strobe), 32'h0);
   endtask

   task automatic t_startup();
      rst = 1'b0;
      tick();
      chk("R2", "rd in interrupt phase", 32'(pm_rd), 32'h0);
      tick();
      chk("R2", "rd in first fetch", 32'(pm_rd), 32'h1);
      chk("R3", "fetch address", 32'(pm_addr), 32'h0);
      tick();
      chk("R3", "rd after fetch", 32'(pm_rd), 32'h0);
      chk("R5", "strobe first exec", 32'(ex_strobe), 32'h1);
      chk("R4", "opcode latched", 32'(ex_opcode), 32'(exp_op(16'h0, key)));
   endtask

   task automatic t_hold();
      logic [7:0] held;
      held = ex_opcode;
      key = 8'h3C;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R5", "strobe low in later exec", 32'(ex_strobe), 32'h0);
         chk("R6", "pc held while not done", 32'(pm_addr), 32'h0);
         chk("R4", "opcode held", 32'(ex_opcode), 32'(held));
      end
      ex_done = 1'b1;
      tick();
      chk("R6", "pc advanced on done", 32'(pm_addr), 32'h1);
      chk("R7", "rd low in interrupt", 32'(pm_rd), 32'h0);
   endtask

   task automatic t_ignore();
      // ex_done stays high through interrupt and fetch
      tick();
      chk("R6", "done ignored in interrupt", 32'(pm_addr), 32'h1);
      chk("R7", "fetch after one interrupt cycle", 32'(pm_rd), 32'h1);
      tick();
      chk("R6", "done ignored in fetch", 32'(pm_addr), 32'h1);
      chk("R5", "strobe", 32'(ex_strobe), 32'h1);
      chk("R4", "opcode second", 32'(ex_opcode), 32'(exp_op(16'h1, key)));
      tick();
      chk("R9", "zero-wait advance", 32'(pm_addr), 32'h2);
      ex_done = 1'b0;
   endtask

   task automatic t_stream();
      for (int n = 2; n < 16; n++) begin
         key = 8'(n * 7);
         tick();
         chk("R9", "fetch two cycles after done", 32'(pm_rd), 32'h1);
         tick();
         chk("R9", "strobe", 32'(ex_strobe), 32'h1);
         chk("R4", "opcode stream", 32'(ex_opcode), 32'(exp_op(16'(n), key)));
         ex_done = 1'b1;
         tick();
         ex_done = 1'b0;
         chk("R9", "address step", 32'(pm_addr), 32'(n + 1));
      end
      chk("R8", "narrow pc wrapped", 32'(s_addr), 32'h0);
      chk("R8", "wide pc continued", 32'(pm_addr), 32'h10);
   endtask

   task automatic t_reset_mid();
      tick();
      chk("R3", "fetch before reset", 32'(pm_rd), 32'h1);
      rst = 1'b1;
      tick();
      chk("R1", "reset from fetch addr", 32'(pm_addr), 32'h0);
      chk("R1", "reset from fetch strobe", 32'(ex_strobe), 32'h0);
      rst = 1'b0;
      tick();
      tick();
      chk("R2", "refetch", 32'(pm_rd), 32'h1);
      tick();
      chk("R5", "strobe after restart", 32'(ex_strobe), 32'h1);
      rst = 1'b1;
      ex_done = 1'b1;
      tick();
      chk("R1", "reset beats done addr", 32'(pm_addr), 32'h0);
      chk("R1", "reset beats done rd", 32'(pm_rd), 32'h0);
      chk("R1", "narrow reset beats done", 32'(s_addr), 32'h0);
      rst = 1'b0;
      ex_done = 1'b0;
      tick();
      chk("R2", "interrupt after release", 32'(pm_rd), 32'h0);
      tick();
      chk("R2", "fetch after release", 32'(pm_rd), 32'h1);
      chk("R3", "fetch address after reset", 32'(pm_addr), 32'h0);
   endtask

   initial begin
      t_reset();
      t_startup();
      t_hold();
      t_ignore();
      t_stream();
      t_reset_mid();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #40000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule